// File: doc/BRIEF.md
# Banked Scratchpad with Per-Bank Locks

This block is an on-chip scratchpad whose 32-bit words are interleaved across a set of banks. A requester presents one multi-lane request at a time. Each lane has an enable, an operation, a byte address, a size and write data. The block takes the request when it is ready and works through it in one or more internal passes. In each pass, every bank serves at most one distinct word. The requester is stalled (`req_ready` low) until every pass is done. A one-cycle `resp_valid` then presents the read data and the lock result for every lane.

When several lanes need different words from one bank, the block splits the work into conflict-free passes. For each bank, the lowest pending slot wins. Lanes that read the same word as that winner, with no pending write or lock operation between them, are served in the same pass. The read data is broadcast to all of them. This ordering makes a request behave exactly as if its lanes ran one after another in ascending lane order.

Each bank also carries a lock bit. Acquire and release operations set and clear it, and an acquire reports whether the bank was already held. Plain reads and writes never look at the lock bit.

Top module: `smem_banked_lock`

## Requirements
- R1: The byte address of a lane is reduced to a word address by dropping its two low bits. The word's bank is the word address modulo NUM_BANKS, and its row inside the bank is the word address divided by NUM_BANKS.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. If all of its active words lie in distinct banks, or if no lane is enabled, `resp_valid` is high and `req_ready` is high again in the cycle after the acceptance edge.
- R3: When N distinct words, or N operations that are not merged, fall into one bank, that bank needs N passes, one cycle each. The response comes after as many cycles as the busiest bank needs, and `req_ready` stays low until then.
- R4: Lanes that read the same word in one request get the same data. They cost no extra pass, provided no lower lane writes or locks that bank.
- R5: The operation field is 2 bits per lane, at `req_op[2*i+1:2*i]`: 0 is read, 1 is write, 2 is lock-acquire, 3 is lock-release. The outcome of a request (memory contents, read data, lock results) equals running its lanes in ascending lane order.
- R6: Per lane, size 0 moves 4 bytes and size 1 moves 8 bytes, which are two consecutive words and so two banks. The lower word sits in bits [31:0] of the lane's 64-bit data slot. The second word wraps to word 0 past the last word. A 4-byte read returns zeros in bits [63:32].
- R7: A lock-acquire on an unlocked bank sets the bank's bit and returns fail 0. On a locked bank it returns fail 1 and the bit stays set. Lock operations address the bank of the lane's first word, and their size is ignored.
- R8: A lock-release clears the bank's bit and returns fail 0.
- R9: Plain reads and writes complete normally on a locked bank and do not change its lock bit.
- R10: Reset (synchronous, active low) clears every lock bit, raises `req_ready` and lowers `resp_valid`. Memory contents are not defined by reset.
- R11: A disabled lane changes nothing and returns zero data and fail 0. Write and lock lanes also return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_en | input | NUM_LANES | Per-lane enable |
| req_op | input | 2*NUM_LANES | Per-lane operation code |
| req_size | input | NUM_LANES | Per-lane size: 0 = 4 bytes, 1 = 8 bytes |
| req_addr | input | NUM_LANES*(clog2(NUM_BANKS*BANK_ROWS)+2) | Per-lane byte address |
| req_wdata | input | NUM_LANES*64 | Per-lane write data |
| resp_valid | output | 1 | One-cycle pulse when the request is done |
| resp_rdata | output | NUM_LANES*64 | Per-lane read data, held until the next acceptance |
| resp_fail | output | NUM_LANES | Per-lane acquire failure |

## Verification
The bench targets requests where a read, a write and a second read name the same word. A design that merged all the reads would hand the later reader stale data. It also checks that lanes naming one word finish in a single pass, and that lanes naming one bank finish in as many passes as there are lanes. A scheduler that ignored conflicts would corrupt data, and one that never merged would take too many cycles. Further cases cover two acquires of one bank inside one request, 8-byte accesses that wrap at the top of memory, and writes into a locked bank. These expose a lock that is evaluated out of order, a lost wrap, and a lock bit that wrongly blocks plain traffic.

// File: rtl/smem_pkg.sv
// Shared types for the banked scratchpad.
// Assumes: the operation code is two bits wide, one code per lane.
package smem_pkg;
    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_ACQUIRE = 2'd2,
        OP_RELEASE = 2'd3
    } smem_op_e;
endpackage

// File: rtl/smem_bank.sv
// One bank: word storage with a combinational read port, and one lock bit.
// Assumes: at most one of wr_en, lock_set and lock_clr is high in a cycle.
// The storage is not reset; only the lock bit is.
module smem_bank #(
    parameter int ROWS  = 16,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic             lock_set,
    input  logic             lock_clr,
    output logic [31:0]      rdata,
    output logic             locked
);
    logic [31:0] store [ROWS];

    // Write the selected row.
    always_ff @(posedge clk) begin
        if (wr_en) store[row] <= wdata;
    end

    // Read the selected row without a register stage.
    assign rdata = store[row];

    // Hold the bank's lock state.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked <= 1'b0;
        else if (lock_clr) locked <= 1'b0;
        else if (lock_set) locked <= 1'b1;
    end

    // R7: an acquire always leaves the bank locked.
    assert_acquire_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_set |=> locked);
    // R8: a release always leaves the bank unlocked.
    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_clr |=> !locked);
    // R9: plain writes leave the lock bit alone.
    assert_write_keeps_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock_set && !lock_clr) |=> (locked == $past(locked)));
    // R10: a reset cycle leaves the bank unlocked.
    assert_reset_unlocks_R10: assert property (@(posedge clk)
        !rst_n |=> !locked);
endmodule

// File: rtl/smem_pass_sel.sv
// Per-pass scheduler. Each bank is given to its lowest pending slot.
// A read slot rides along with that winner when the winner is a read of the
// same word and no lower pending write or lock slot sits on the bank.
// Assumes: slot order is lane order, with the first word of a lane before its second.
module smem_pass_sel #(
    parameter int SLOTS     = 8,
    parameter int NUM_BANKS = 8,
    parameter int WADDR_W   = 7,
    parameter int SIDX_W    = $clog2(SLOTS),
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic [SLOTS-1:0]                pend,
    input  logic [SLOTS-1:0][WADDR_W-1:0]   slot_word,
    input  logic [SLOTS-1:0]                slot_rd,
    output logic [SLOTS-1:0]                served,
    output logic [NUM_BANKS-1:0]            bank_act,
    output logic [NUM_BANKS-1:0][SIDX_W-1:0] bank_win
);
    logic [NUM_BANKS-1:0]             act_v;
    logic [NUM_BANKS-1:0][SIDX_W-1:0] win_v;

    // Pick the lowest pending slot per bank.
    always_comb begin
        act_v = '0;
        win_v = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (pend[s] && !act_v[slot_word[s][BANK_W-1:0]]) begin
                act_v[slot_word[s][BANK_W-1:0]] = 1'b1;
                win_v[slot_word[s][BANK_W-1:0]] = SIDX_W'(s);
            end
        end
    end

    // Mark the winners and the reads that may merge with them.
    always_comb begin
        served = '0;
        for (int s = 0; s < SLOTS; s++) begin
            logic                blocked;
            logic [SIDX_W-1:0]   w;
            blocked = 1'b0;
            w = win_v[slot_word[s][BANK_W-1:0]];
            for (int t = 0; t < SLOTS; t++) begin
                if (t < s && pend[t] && !slot_rd[t] &&
                    slot_word[t][BANK_W-1:0] == slot_word[s][BANK_W-1:0])
                    blocked = 1'b1;
            end
            served[s] = pend[s] && ((w == SIDX_W'(s)) ||
                        (slot_rd[s] && slot_rd[w] && !blocked &&
                         slot_word[w] == slot_word[s]));
        end
    end

    assign bank_act = act_v;
    assign bank_win = win_v;
endmodule

// File: rtl/smem_banked_lock.sv
// Banked scratchpad top. It latches one multi-lane request and runs
// conflict-free passes through smem_pass_sel, one per cycle. When nothing is
// left pending it pulses resp_valid.
// Assumes: the requester holds its inputs only for the acceptance cycle, and
// the data out is valid while resp_valid is high and until the next acceptance.
module smem_banked_lock
    import smem_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int NUM_BANKS = 8,
    parameter int BANK_ROWS = 16
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                req_valid,
    output logic                                                req_ready,
    input  logic [NUM_LANES-1:0]                                req_en,
    input  logic [2*NUM_LANES-1:0]                              req_op,
    input  logic [NUM_LANES-1:0]                                req_size,
    input  logic [NUM_LANES*($clog2(NUM_BANKS*BANK_ROWS)+2)-1:0] req_addr,
    input  logic [NUM_LANES*64-1:0]                             req_wdata,
    output logic                                                resp_valid,
    output logic [NUM_LANES*64-1:0]                             resp_rdata,
    output logic [NUM_LANES-1:0]                                resp_fail
);
    localparam int WORDS   = NUM_BANKS * BANK_ROWS;
    localparam int WADDR_W = $clog2(WORDS);
    localparam int ADDR_W  = WADDR_W + 2;
    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int SLOTS   = 2 * NUM_LANES;
    localparam int SIDX_W  = $clog2(SLOTS);

    logic                          busy;
    logic [SLOTS-1:0]              pend;
    logic [SLOTS-1:0]              live_in;
    smem_op_e                      op_q   [NUM_LANES];
    logic [NUM_LANES-1:0][WADDR_W-1:0] word_q;
    logic [NUM_LANES-1:0][63:0]    wdata_q;
    logic [NUM_LANES*64-1:0]       rdata_q;
    logic [NUM_LANES-1:0]          fail_q;

    logic [SLOTS-1:0][WADDR_W-1:0] slot_word;
    logic [SLOTS-1:0]              slot_rd;
    smem_op_e                      slot_op [SLOTS];
    logic [SLOTS-1:0][31:0]        slot_wdata;
    logic [SLOTS-1:0]              served;
    logic [NUM_BANKS-1:0]          bank_act;
    logic [NUM_BANKS-1:0][SIDX_W-1:0] bank_win;
    logic [NUM_BANKS-1:0][31:0]    bank_rdata;
    logic [NUM_BANKS-1:0]          bank_locked;

    assign req_ready  = !busy;
    assign resp_rdata = rdata_q;
    assign resp_fail  = fail_q;

    // Decide which slots of an incoming request carry real work.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            smem_op_e op_in;
            op_in = smem_op_e'(req_op[2*(s/2) +: 2]);
            live_in[s] = req_en[s/2] &&
                         ((s % 2 == 0) ||
                          (req_size[s/2] && (op_in == OP_READ || op_in == OP_WRITE)));
        end
    end

    // Expand the latched lanes into per-word slots.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            slot_word[s]  = word_q[s/2] + WADDR_W'(s % 2);
            slot_op[s]    = op_q[s/2];
            slot_rd[s]    = (op_q[s/2] == OP_READ);
            slot_wdata[s] = wdata_q[s/2][32*(s%2) +: 32];
        end
    end

    smem_pass_sel #(
        .SLOTS(SLOTS), .NUM_BANKS(NUM_BANKS), .WADDR_W(WADDR_W)
    ) u_sel (
        .pend(pend), .slot_word(slot_word), .slot_rd(slot_rd),
        .served(served), .bank_act(bank_act), .bank_win(bank_win)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [SIDX_W-1:0] win;
        smem_op_e          wop;
        logic              go;
        assign win = bank_win[b];
        assign wop = slot_op[win];
        assign go  = busy && bank_act[b];

        smem_bank #(.ROWS(BANK_ROWS)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .row(slot_word[win][WADDR_W-1:BANK_W]),
            .wr_en(go && wop == OP_WRITE),
            .wdata(slot_wdata[win]),
            .lock_set(go && wop == OP_ACQUIRE),
            .lock_clr(go && wop == OP_RELEASE),
            .rdata(bank_rdata[b]),
            .locked(bank_locked[b])
        );
    end

    // Latch the lanes on acceptance, then retire one pass per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            resp_valid <= 1'b0;
            pend       <= '0;
            rdata_q    <= '0;
            fail_q     <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    busy    <= 1'b1;
                    pend    <= live_in;
                    rdata_q <= '0;
                    fail_q  <= '0;
                    for (int l = 0; l < NUM_LANES; l++) begin
                        op_q[l]    <= smem_op_e'(req_op[2*l +: 2]);
                        word_q[l]  <= req_addr[l*ADDR_W+2 +: WADDR_W];
                        wdata_q[l] <= req_wdata[64*l +: 64];
                    end
                end
            end else begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (served[s] && slot_rd[s])
                        rdata_q[64*(s/2) + 32*(s%2) +: 32] <= bank_rdata[slot_word[s][BANK_W-1:0]];
                    if (served[s] && slot_op[s] == OP_ACQUIRE)
                        fail_q[s/2] <= bank_locked[slot_word[s][BANK_W-1:0]];
                end
                pend <= pend & ~served;
                if ((pend & ~served) == '0) begin
                    busy       <= 1'b0;
                    resp_valid <= 1'b1;
                end
            end
        end
    end

    // R3: once a request is taken the requester is stalled.
    assert_stall_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R3: every busy cycle with work left retires at least one slot.
    assert_pass_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (|pend)) |-> (|served));
    // R2: the response coincides with readiness for the next request.
    assert_resp_when_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
        // R4: only reads may share a bank with its winner in one pass.
        assert_merge_reads_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && served[s] && bank_win[slot_word[s][BANK_W-1:0]] != SIDX_W'(s))
            |-> slot_rd[s]);
    end
endmodule

// File: tb/smem_banked_lock_tb.sv
module smem_banked_lock_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 4;
    localparam int NB = 8;
    localparam int NR = 16;
    localparam int W  = NB * NR;
    localparam int AW = $clog2(W) + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [L-1:0]      req_en = '0;
    logic [2*L-1:0]    req_op = '0;
    logic [L-1:0]      req_size = '0;
    logic [L*AW-1:0]   req_addr = '0;
    logic [L*64-1:0]   req_wdata = '0;
    logic              resp_valid;
    logic [L*64-1:0]   resp_rdata;
    logic [L-1:0]      resp_fail;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Staged lane fields and the bench's own model state.
    bit [1:0]   s_op   [L];
    bit         s_en   [L];
    bit         s_size [L];
    int         s_word [L];
    int         s_lo   [L];
    bit [63:0]  s_wd   [L];
    bit [31:0]  m   [W];
    bit         lk  [NB];
    bit [63:0]  e_rd [L];
    bit         e_fl [L];
    int         lat;

    smem_banked_lock #(.NUM_LANES(L), .NUM_BANKS(NB), .BANK_ROWS(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_en(req_en), .req_op(req_op), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .resp_fail(resp_fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
            finish_run();
        end
    end

    task automatic clear_lanes();
        for (int l = 0; l < L; l++) begin
            s_op[l] = 2'd0; s_en[l] = 1'b0; s_size[l] = 1'b0;
            s_word[l] = 0; s_lo[l] = 0; s_wd[l] = '0;
        end
    endtask

    task automatic set_lane(input int l, input bit [1:0] op, input int word,
                            input bit sz, input bit [63:0] wd);
        s_en[l] = 1'b1; s_op[l] = op; s_word[l] = word % W;
        s_size[l] = sz; s_wd[l] = wd; s_lo[l] = 0;
    endtask

    // Sequential lane-order model (R5, R6, R7, R8, R9, R11).
    task automatic model();
        for (int l = 0; l < L; l++) begin
            e_rd[l] = '0; e_fl[l] = 1'b0;
            if (s_en[l]) begin
                int b0;
                b0 = s_word[l] % NB;
                case (s_op[l])
                    2'd0: for (int k = 0; k <= int'(s_size[l]); k++)
                              e_rd[l][32*k +: 32] = m[(s_word[l] + k) % W];
                    2'd1: for (int k = 0; k <= int'(s_size[l]); k++)
                              m[(s_word[l] + k) % W] = s_wd[l][32*k +: 32];
                    2'd2: begin e_fl[l] = lk[b0]; lk[b0] = 1'b1; end
                    default: lk[b0] = 1'b0;
                endcase
            end
        end
    endtask

    // Drive one request, measure its pass count, compare all lanes.
    task automatic issue(input string tag);
        @(negedge clk);
        for (int l = 0; l < L; l++) begin
            req_en[l] = s_en[l];
            req_op[2*l +: 2] = s_op[l];
            req_size[l] = s_size[l];
            req_addr[l*AW +: AW] = AW'(s_word[l] * 4 + s_lo[l]);
            req_wdata[64*l +: 64] = s_wd[l];
        end
        req_valid = 1'b1;
        model();
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        for (int i = 0; i < 64; i++) begin
            if (resp_valid) break;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        if (!resp_valid) chk(1'b0, {tag, " R2 no response"}, 64'(lat), 64'd0);
        for (int l = 0; l < L; l++) begin
            chk(resp_rdata[64*l +: 64] == e_rd[l], {tag, " R5 rdata"},
                resp_rdata[64*l +: 64], e_rd[l]);
            chk(resp_fail[l] == e_fl[l], {tag, " R7 fail"}, 64'(resp_fail[l]), 64'(e_fl[l]));
        end
    endtask

    task automatic init_mem();
        for (int r = 0; r < W / (2 * L); r++) begin
            clear_lanes();
            for (int l = 0; l < L; l++) begin
                int w;
                w = r * 2 * L + 2 * l;
                set_lane(l, 2'd1, w, 1'b1,
                         {32'hC3000000 ^ (w + 1) * 32'h00010203, 32'hA5000000 ^ w * 32'h01010101});
            end
            issue("init");
            if (r == 0) chk(lat == 1, "R2 distinct banks one pass", 64'(lat), 64'd1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) lk[b] = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        clear_lanes();
        for (int b = 0; b < NB; b++) lk[b] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R10 no response in reset", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after release", 64'(req_ready), 64'd1);

        init_mem();

        // R1 / R2: four consecutive words land in four banks.
        clear_lanes();
        for (int l = 0; l < L; l++) set_lane(l, 2'd0, 40 + l, 1'b0, '0);
        s_lo[1] = 3;
        issue("R1 consecutive");
        chk(lat == 1, "R1 consecutive words one pass", 64'(lat), 64'd1);

        // R1 / R3: stride of NUM_BANKS words hits one bank every time.
        clear_lanes();
        for (int l = 0; l < L; l++) set_lane(l, 2'd0, 3 + NB * l, 1'b0, '0);
        issue("R3 same bank");
        chk(lat == L, "R3 one pass per conflicting word", 64'(lat), 64'(L));

        // R4: all lanes read one word.
        clear_lanes();
        for (int l = 0; l < L; l++) set_lane(l, 2'd0, 77, 1'b0, '0);
        issue("R4 broadcast");
        chk(lat == 1, "R4 broadcast single pass", 64'(lat), 64'd1);

        // R5: read, write, read, write of one word keep lane order.
        clear_lanes();
        set_lane(0, 2'd0, 9, 1'b0, '0);
        set_lane(1, 2'd1, 9, 1'b0, 64'h1111_2222);
        set_lane(2, 2'd0, 9, 1'b0, '0);
        set_lane(3, 2'd1, 9, 1'b0, 64'h3333_4444);
        issue("R5 ordering");
        chk(resp_rdata[64*2 +: 32] == 32'h1111_2222, "R5 later read sees earlier write",
            64'(resp_rdata[64*2 +: 32]), 64'h1111_2222);
        clear_lanes();
        set_lane(0, 2'd0, 9, 1'b0, '0);
        issue("R5 readback");
        chk(resp_rdata[31:0] == 32'h3333_4444, "R5 last writer wins",
            64'(resp_rdata[31:0]), 64'h3333_4444);

        // R6: 8-byte write and read wrapping at the top of memory.
        clear_lanes();
        set_lane(0, 2'd1, W - 1, 1'b1, 64'hDEAD_BEEF_0BAD_F00D);
        issue("R6 wrap write");
        clear_lanes();
        set_lane(0, 2'd0, W - 1, 1'b1, '0);
        set_lane(1, 2'd0, 0, 1'b0, '0);
        issue("R6 wrap read");
        chk(resp_rdata[63:0] == 64'hDEAD_BEEF_0BAD_F00D, "R6 two words with wrap",
            resp_rdata[63:0], 64'hDEAD_BEEF_0BAD_F00D);
        chk(resp_rdata[127:96] == 32'h0, "R6 short read upper half zero",
            64'(resp_rdata[127:96]), 64'd0);

        // R7: acquire twice across requests and twice inside one request.
        clear_lanes();
        set_lane(0, 2'd2, 2, 1'b0, '0);
        issue("R7 first acquire");
        chk(resp_fail[0] == 1'b0, "R7 free bank acquire", 64'(resp_fail[0]), 64'd0);
        clear_lanes();
        set_lane(0, 2'd2, 2 + NB, 1'b1, '0);
        set_lane(1, 2'd2, 3, 1'b0, '0);
        set_lane(2, 2'd2, 3 + NB, 1'b0, '0);
        issue("R7 contended acquire");
        chk(resp_fail[0] == 1'b1, "R7 held bank acquire fails", 64'(resp_fail[0]), 64'd1);
        chk(resp_fail[2] == 1'b1, "R7 second in-request acquire fails", 64'(resp_fail[2]), 64'd1);

        // R9: plain traffic on a locked bank.
        clear_lanes();
        set_lane(0, 2'd1, 2, 1'b0, 64'h5A5A_5A5A);
        set_lane(1, 2'd0, 2, 1'b0, '0);
        issue("R9 locked bank");
        chk(resp_rdata[64 +: 32] == 32'h5A5A_5A5A, "R9 write then read on locked bank",
            64'(resp_rdata[64 +: 32]), 64'h5A5A_5A5A);
        clear_lanes();
        set_lane(0, 2'd2, 2, 1'b0, '0);
        issue("R9 lock kept");
        chk(resp_fail[0] == 1'b1, "R9 plain access left lock set", 64'(resp_fail[0]), 64'd1);

        // R8: release then acquire again.
        clear_lanes();
        set_lane(0, 2'd3, 2, 1'b0, '0);
        set_lane(1, 2'd2, 2, 1'b0, '0);
        issue("R8 release");
        chk(resp_fail[1] == 1'b0, "R8 acquire after release", 64'(resp_fail[1]), 64'd0);

        // R11: disabled lane with a write leaves memory untouched.
        clear_lanes();
        set_lane(0, 2'd1, 50, 1'b0, 64'hFFFF_FFFF);
        s_en[0] = 1'b0;
        set_lane(1, 2'd1, 51, 1'b0, 64'h0000_0077);
        issue("R11 disabled");
        chk(resp_rdata[63:0] == 64'd0, "R11 disabled lane data zero", resp_rdata[63:0], 64'd0);
        clear_lanes();
        set_lane(0, 2'd0, 50, 1'b0, '0);
        issue("R11 readback");
        chk(resp_rdata[31:0] == m[50], "R11 disabled write had no effect",
            64'(resp_rdata[31:0]), 64'(m[50]));
        clear_lanes();
        issue("R2 empty");
        chk(lat == 1, "R2 empty request one cycle", 64'(lat), 64'd1);

        // R10: reset drops held locks.
        do_reset();
        chk(req_ready == 1'b1, "R10 ready after mid reset", 64'(req_ready), 64'd1);
        init_mem();
        clear_lanes();
        set_lane(0, 2'd2, 3, 1'b0, '0);
        issue("R10 locks cleared");
        chk(resp_fail[0] == 1'b0, "R10 acquire after reset", 64'(resp_fail[0]), 64'd0);

        // Random mix over a small window to force conflicts (R3, R4, R5).
        for (int n = 0; n < 400; n++) begin
            clear_lanes();
            for (int l = 0; l < L; l++) begin
                int r;
                bit [1:0] op;
                r = int'($urandom % 10);
                op = (r < 4) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
                set_lane(l, op, int'($urandom % 24), 1'($urandom), {$urandom, $urandom});
                s_en[l] = ($urandom % 6) != 0;
                s_lo[l] = int'($urandom % 4);
            end
            issue("random");
            chk(lat >= 1 && lat <= 2 * L, "R3 pass count bound", 64'(lat), 64'(2 * L));
        end

        finish_run();
    end
endmodule